// File: doc/BRIEF.md
# TDM Network-Mode Serial Transmitter

This block drives a time-division-multiplexed serial link that carries up to four word slots per frame. It generates the frame sync, shifts each word out MSB first, and releases the data output enable whenever the current slot does not belong to the transmitter. That way other talkers can share the line. Each slot takes its word from one of two places, set per slot: a shared transmit FIFO, or a single-word holding register for that slot that a DMA engine fills. The block also raises a FIFO low-level interrupt and a request per slot while that slot's holding register is empty.

Bit timing comes from a one-cycle `bit_tick_i` strobe, and every output changes only on a tick. Setting `enable_i` starts a frame. The first tick is a priming tick: it fetches the slot 0 word while the outputs stay idle. The second tick shows the first bit of slot 0. Each slot's word is always fetched on the tick before that slot begins. In synchronous mode the block also pulses two auxiliary sync outputs at the starts of slots 1 and 2, so that up to three codecs can each be addressed by their own sync.

Top module: `tdm_net_tx`

## Requirements
- R1: A frame holds `last_slot_i`+1 slots of 8 bits each, in slot order from 0. After the last bit of the last slot, the next tick starts slot 0 again.
- R2: An assigned slot (`tx_assign_i[s]`=1) with `dma_en_i[s]`=0 sends the word at the head of the FIFO, MSB first. FIFO words are used in slot order.
- R3: An assigned slot with `dma_en_i[s]`=1 sends the word in holding register s and empties it. A write on `dma_wr_i[s]` fills it. `dma_req_o[s]` is high exactly when `dma_en_i[s]`=1 and register s is empty.
- R4: `tx_irq_o` is high exactly when `fifo_level_o` ≤ `warn_lvl_i`.
- R5: During a slot with `tx_assign_i[s]`=0, `sd_oe_o` is 0 and `sd_o` is 0. During an assigned slot, `sd_oe_o` is 1 for all 8 bits.
- R6: With `long_fs_i`=0, `fs_o` is high only during bit 0 of slot 0. With `long_fs_i`=1, it is high for every bit of slot 0.
- R7: With `sync_mode_i`=1, `aux_fs1_o` and `aux_fs2_o` behave like `fs_o` but for slot 1 and slot 2 respectively: one bit long in short mode, the whole slot long in long mode. With `sync_mode_i`=0 both stay 0.
- R8: If the chosen source is empty when a slot's word is fetched, the slot sends all zeros with `sd_oe_o`=1. It also sets `underrun_o`, which stays set until `underrun_clr_i` is pulsed.
- R9: The first tick after `enable_i` rises leaves `sd_oe_o` and `fs_o` at 0. A tick while `enable_i`=0 returns `sd_oe_o` and all syncs to 0.
- R10: `fifo_full_o` is high when `fifo_level_o` is 8. A write to a full FIFO is dropped.
- R11: After reset, all serial outputs, `fifo_level_o`, `underrun_o` and `dma_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| bit_tick_i | input | 1 | one-cycle strobe per serial bit period |
| enable_i | input | 1 | run the transmitter |
| sync_mode_i | input | 1 | drive the auxiliary slot syncs |
| long_fs_i | input | 1 | syncs span their whole slot |
| last_slot_i | input | 2 | number of slots per frame minus one |
| tx_assign_i | input | 4 | slot owned by this transmitter |
| dma_en_i | input | 4 | slot sourced from its holding register |
| warn_lvl_i | input | 4 | FIFO low-level interrupt threshold |
| fifo_wr_i | input | 1 | FIFO write strobe |
| fifo_wdata_i | input | 8 | FIFO write word |
| fifo_full_o | output | 1 | FIFO full |
| fifo_level_o | output | 4 | words held in the FIFO |
| dma_wr_i | input | 4 | per-slot holding register write strobe |
| dma_wdata_i | input | 8 | holding register write word |
| dma_req_o | output | 4 | per-slot refill request |
| tx_irq_o | output | 1 | FIFO at or below threshold |
| underrun_clr_i | input | 1 | clear the underrun flag |
| underrun_o | output | 1 | sticky underrun flag |
| sd_o | output | 1 | serial data |
| sd_oe_o | output | 1 | serial data output enable |
| fs_o | output | 1 | frame sync at slot 0 |
| aux_fs1_o | output | 1 | auxiliary sync at slot 1 |
| aux_fs2_o | output | 1 | auxiliary sync at slot 2 |

## Verification
The vector walk mixes FIFO-sourced and register-sourced slots with gaps in the slot assignment. A design that advanced the FIFO on unassigned or register-sourced slots would send words out of order, and one that kept the output enable high through a gap would collide with other talkers. Each vector also samples one bit past the frame end to catch a design that wraps at a fixed four slots rather than at the programmed count. It samples the syncs in both short and long mode, which exposes a sync that lasts a whole slot when it should last one bit, or the reverse. Directed tests empty each source before its slot starts to confirm zeros and a flag that does not clear by itself. They also check that the priming tick keeps the line idle, which catches a design that sends a stale word ahead of the first real slot.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_FIFO = 2'd1,
    SRC_DMA  = 2'd2
  } src_e;
endpackage

// File: rtl/tdm_tx_fifo.sv
module tdm_tx_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [LW-1:0] level_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] lvl_q;
  logic          do_push, do_pop;

  assign empty_o = lvl_q == '0;
  assign full_o  = lvl_q == LW'(DEPTH);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];
  assign level_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LW'(DEPTH)); // R10
  AST_FULL_DROPS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> $stable(lvl_q)); // R10
endmodule

// File: rtl/tdm_tx_dma.sv
module tdm_tx_dma #(
  parameter int SLOTS = 4,
  parameter int W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [SLOTS-1:0]           wr_i,
  input  logic [W-1:0]               wdata_i,
  input  logic [SLOTS-1:0]           take_i,
  input  logic [SLOTS-1:0]           en_i,
  output logic [SLOTS-1:0][W-1:0]    data_o,
  output logic [SLOTS-1:0]           full_o,
  output logic [SLOTS-1:0]           req_o
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [W-1:0] data_q;
    logic         full_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        full_q <= 1'b0;
      end else if (wr_i[s]) begin
        data_q <= wdata_i;
        full_q <= 1'b1;
      end else if (take_i[s]) begin
        full_q <= 1'b0;
      end
    end

    assign data_o[s] = data_q;
    assign full_o[s] = full_q;
    assign req_o[s]  = en_i[s] && !full_q;

    AST_WRITE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i[s] |=> full_q); // R3
    AST_TAKE_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i[s] |-> full_q); // R3
  end
endmodule

// File: rtl/tdm_tx_timing.sv
module tdm_tx_timing #(
  parameter int SLOTS = 4,
  parameter int W = 8,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          enable_i,
  input  logic [SW-1:0] last_slot_i,
  input  logic          long_i,
  input  logic          sync_i,
  output logic          fetch_o,
  output logic [SW-1:0] fetch_slot_o,
  output logic          show_o,
  output logic          show_first_o,
  output logic          fs_o,
  output logic          aux1_o,
  output logic          aux2_o
);
  logic          run_q;
  logic [SW-1:0] slot_q;
  logic [BW-1:0] bit_q;
  logic          fs_q, aux1_q, aux2_q;
  logic          last_bit, wrap, mark;

  assign last_bit = bit_q == BW'(W-1);
  assign wrap     = slot_q >= last_slot_i;
  assign mark     = long_i || (bit_q == '0);

  // fetch happens on the tick before a slot's first bit
  assign fetch_o      = tick_i && enable_i && (!run_q || last_bit);
  assign fetch_slot_o = (!run_q || wrap) ? '0 : slot_q + 1'b1;
  assign show_o       = tick_i && enable_i && run_q;
  assign show_first_o = bit_q == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      slot_q <= '0;
      bit_q  <= '0;
      fs_q   <= 1'b0;
      aux1_q <= 1'b0;
      aux2_q <= 1'b0;
    end else if (tick_i) begin
      if (!enable_i || !run_q) begin
        run_q  <= enable_i;
        slot_q <= '0;
        bit_q  <= '0;
        fs_q   <= 1'b0;
        aux1_q <= 1'b0;
        aux2_q <= 1'b0;
      end else begin
        fs_q   <= (slot_q == SW'(0)) && mark;
        aux1_q <= sync_i && (slot_q == SW'(1)) && mark;
        aux2_q <= sync_i && (slot_q == SW'(2)) && mark;
        bit_q  <= last_bit ? '0 : bit_q + 1'b1;
        if (last_bit) slot_q <= wrap ? '0 : slot_q + 1'b1;
      end
    end
  end

  assign fs_o   = fs_q;
  assign aux1_o = aux1_q;
  assign aux2_o = aux2_q;

  AST_SYNC_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fs_q, aux1_q, aux2_q})); // R7
  AST_SHORT_FS_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_q && !long_i && show_o) |=> !fs_q); // R6
  AST_AUX_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !sync_i) |=> (!aux1_q && !aux2_q)); // R7
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         show_i,
  input  logic         first_i,
  input  logic [W-1:0] word_i,
  input  logic         word_oe_i,
  output logic         sd_o,
  output logic         oe_o
);
  logic [W-1:0] sh_q;
  logic         oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else if (tick_i) begin
      if (!show_i) begin
        oe_q <= 1'b0;
      end else if (first_i) begin
        sh_q <= word_i;
        oe_q <= word_oe_i;
      end else begin
        sh_q <= {sh_q[W-2:0], 1'b0};
      end
    end
  end

  assign sd_o = oe_q && sh_q[W-1];
  assign oe_o = oe_q;

  AST_IDLE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !show_i) |=> !oe_q); // R9
  AST_OE_HOLDS_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && show_i && !first_i) |=> $stable(oe_q)); // R5
endmodule

// File: rtl/tdm_net_tx.sv
module tdm_net_tx #(
  parameter int SLOTS = 4,
  parameter int W = 8,
  parameter int DEPTH = 8,
  localparam int SW = $clog2(SLOTS),
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic             enable_i,
  input  logic             sync_mode_i,
  input  logic             long_fs_i,
  input  logic [SW-1:0]    last_slot_i,
  input  logic [SLOTS-1:0] tx_assign_i,
  input  logic [SLOTS-1:0] dma_en_i,
  input  logic [LW-1:0]    warn_lvl_i,
  input  logic             fifo_wr_i,
  input  logic [W-1:0]     fifo_wdata_i,
  output logic             fifo_full_o,
  output logic [LW-1:0]    fifo_level_o,
  input  logic [SLOTS-1:0] dma_wr_i,
  input  logic [W-1:0]     dma_wdata_i,
  output logic [SLOTS-1:0] dma_req_o,
  output logic             tx_irq_o,
  input  logic             underrun_clr_i,
  output logic             underrun_o,
  output logic             sd_o,
  output logic             sd_oe_o,
  output logic             fs_o,
  output logic             aux_fs1_o,
  output logic             aux_fs2_o
);
  import tdm_tx_pkg::*;

  logic                    fetch, show, show_first;
  logic [SW-1:0]           fetch_slot;
  logic [W-1:0]            fifo_rdata;
  logic                    fifo_empty, fifo_pop;
  logic [SLOTS-1:0][W-1:0] dma_data;
  logic [SLOTS-1:0]        dma_full, dma_take;
  src_e                    src;
  logic                    starve;
  logic [W-1:0]            pend_q;
  logic                    pend_oe_q, urun_q;

  tdm_tx_timing #(.SLOTS(SLOTS), .W(W)) i_timing (
    .clk_i, .rst_ni,
    .tick_i       (bit_tick_i),
    .enable_i,
    .last_slot_i,
    .long_i       (long_fs_i),
    .sync_i       (sync_mode_i),
    .fetch_o      (fetch),
    .fetch_slot_o (fetch_slot),
    .show_o       (show),
    .show_first_o (show_first),
    .fs_o,
    .aux1_o       (aux_fs1_o),
    .aux2_o       (aux_fs2_o)
  );

  always_comb begin
    if (!tx_assign_i[fetch_slot]) src = SRC_NONE;
    else if (dma_en_i[fetch_slot]) src = SRC_DMA;
    else src = SRC_FIFO;
  end

  assign fifo_pop = fetch && (src == SRC_FIFO);
  assign starve   = fetch && (((src == SRC_FIFO) && fifo_empty) ||
                              ((src == SRC_DMA) && !dma_full[fetch_slot]));

  always_comb begin
    dma_take = '0;
    if (fetch && (src == SRC_DMA)) dma_take[fetch_slot] = dma_full[fetch_slot];
  end

  tdm_tx_fifo #(.W(W), .DEPTH(DEPTH)) i_fifo (
    .clk_i, .rst_ni,
    .push_i  (fifo_wr_i),
    .wdata_i (fifo_wdata_i),
    .pop_i   (fifo_pop),
    .rdata_o (fifo_rdata),
    .empty_o (fifo_empty),
    .full_o  (fifo_full_o),
    .level_o (fifo_level_o)
  );

  tdm_tx_dma #(.SLOTS(SLOTS), .W(W)) i_dma (
    .clk_i, .rst_ni,
    .wr_i    (dma_wr_i),
    .wdata_i (dma_wdata_i),
    .take_i  (dma_take),
    .en_i    (dma_en_i),
    .data_o  (dma_data),
    .full_o  (dma_full),
    .req_o   (dma_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= '0;
      pend_oe_q <= 1'b0;
      urun_q    <= 1'b0;
    end else begin
      if (fetch) begin
        pend_oe_q <= src != SRC_NONE;
        unique case (src)
          SRC_FIFO: pend_q <= fifo_empty ? '0 : fifo_rdata;
          SRC_DMA:  pend_q <= dma_full[fetch_slot] ? dma_data[fetch_slot] : '0;
          default:  pend_q <= '0;
        endcase
      end
      if (starve) urun_q <= 1'b1;
      else if (underrun_clr_i) urun_q <= 1'b0;
    end
  end

  tdm_tx_ser #(.W(W)) i_ser (
    .clk_i, .rst_ni,
    .tick_i    (bit_tick_i),
    .show_i    (show),
    .first_i   (show_first),
    .word_i    (pend_q),
    .word_oe_i (pend_oe_q),
    .sd_o,
    .oe_o      (sd_oe_o)
  );

  assign tx_irq_o   = fifo_level_o <= warn_lvl_i;
  assign underrun_o = urun_q;

  AST_UNDERRUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urun_q && !underrun_clr_i) |=> urun_q); // R8
  AST_STARVE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    starve |=> urun_q); // R8
endmodule

// File: tb/test_tdm_net_tx.sv
module test_tdm_net_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1, en = 1'b0, sync = 1'b0, lfs = 1'b0;
  logic [1:0] last = 2'd3;
  logic [3:0] asg = '0, den = '0, warn = '0;
  logic       fwr = 1'b0;
  logic [7:0] fdat = '0;
  logic       ffull;
  logic [3:0] flvl;
  logic [3:0] dwr = '0;
  logic [7:0] ddat = '0;
  logic [3:0] dreq;
  logic       irq, uclr = 1'b0, urun, sd, oe, fs, ax1, ax2;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  tdm_net_tx i_tdm_net_tx (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .enable_i(en),
    .sync_mode_i(sync), .long_fs_i(lfs), .last_slot_i(last),
    .tx_assign_i(asg), .dma_en_i(den), .warn_lvl_i(warn),
    .fifo_wr_i(fwr), .fifo_wdata_i(fdat), .fifo_full_o(ffull),
    .fifo_level_o(flvl), .dma_wr_i(dwr), .dma_wdata_i(ddat),
    .dma_req_o(dreq), .tx_irq_o(irq), .underrun_clr_i(uclr),
    .underrun_o(urun), .sd_o(sd), .sd_oe_o(oe), .fs_o(fs),
    .aux_fs1_o(ax1), .aux_fs2_o(ax2)
  );

  // {assign, dma_en, long, sync, last_slot}
  localparam logic [11:0] VEC [7] = '{
    {4'hF, 4'h0, 1'b0, 1'b0, 2'd3},
    {4'hF, 4'h3, 1'b0, 1'b1, 2'd3},
    {4'h5, 4'h0, 1'b1, 1'b1, 2'd3},
    {4'hA, 4'h8, 1'b0, 1'b1, 2'd3},
    {4'hF, 4'hF, 1'b1, 1'b0, 2'd3},
    {4'h6, 4'h2, 1'b1, 1'b1, 2'd3},
    {4'h3, 4'h0, 1'b0, 1'b1, 2'd1}
  };

  function automatic logic [7:0] fword(int k);
    return 8'hA5 ^ 8'(k * 8'h3C);
  endfunction
  function automatic logic [7:0] dword(int s);
    return 8'h81 + 8'(s * 8'h26);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    en = 1'b0; fwr = 1'b0; dwr = '0; uclr = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic push_fifo(input logic [7:0] d);
    fdat = d; fwr = 1'b1; @(negedge clk); fwr = 1'b0;
  endtask

  task automatic load_dma(input int s, input logic [7:0] d);
    ddat = d; dwr = 4'(1 << s); @(negedge clk); dwr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    do_reset();
    check("R11 sd_oe", oe, 0); check("R11 fs", fs, 0);
    check("R11 level", flvl, 0); check("R11 underrun", urun, 0);
    check("R11 dma_req", dreq, 0); check("R11 sd", sd, 0);

    for (int v = 0; v < 7; v++) begin
      logic [7:0] word [4];
      logic [3:0] a, d;
      logic       lg, sy;
      int         ns, nb, k;
      {a, d, lg, sy} = VEC[v][11:2];
      ns = int'(VEC[v][1:0]) + 1;
      nb = ns * 8;
      do_reset();
      asg = a; den = d; lfs = lg; sync = sy; last = VEC[v][1:0];
      for (int i = 0; i < 4; i++) push_fifo(fword(i));
      for (int s = 0; s < 4; s++) load_dma(s, dword(s));
      check("R3 req while full", dreq, 0);
      k = 0;
      for (int s = 0; s < 4; s++) begin
        word[s] = 8'h00;
        if (s < ns && a[s]) begin
          if (d[s]) word[s] = dword(s);
          else begin word[s] = fword(k); k++; end
        end
      end
      en = 1'b1;
      @(posedge clk); // priming tick
      for (int i = 0; i <= nb; i++) begin
        int s, b;
        @(posedge clk); @(negedge clk);
        s = i / 8; b = i % 8;
        if (i == nb) begin
          check("R1 frame wraps to slot 0", fs, 1);
          check("R3 req after use", dreq, d & a & 4'((1 << ns) - 1));
        end else begin
          check("R5 sd_oe", oe, a[s]);
          check(d[s] ? "R3 data" : "R2 data", sd, a[s] ? word[s][7-b] : 1'b0);
          check("R6 fs", fs, (s == 0) && (lg || b == 0));
          check("R7 aux1", ax1, sy && (s == 1) && (lg || b == 0));
          check("R7 aux2", ax2, sy && (s == 2) && (lg || b == 0));
        end
      end
      en = 1'b0;
      @(negedge clk);
    end

    // R4 / R10 FIFO levels
    do_reset();
    warn = 4'd2;
    check("R4 irq empty", irq, 1);
    push_fifo(8'h11); push_fifo(8'h22);
    check("R4 irq at limit", irq, 1);
    push_fifo(8'h33);
    check("R4 irq above limit", irq, 0);
    for (int i = 0; i < 6; i++) push_fifo(8'h44);
    check("R10 level full", flvl, 8); check("R10 full flag", ffull, 1);
    push_fifo(8'h55);
    check("R10 write dropped", flvl, 8);

    // R8 FIFO underrun
    do_reset();
    asg = 4'h1; den = 4'h0; last = 2'd0; lfs = 1'b0; sync = 1'b0;
    en = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 prime tick oe", oe, 0); check("R9 prime tick fs", fs, 0);
    check("R8 fifo underrun flag", urun, 1);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); @(negedge clk);
      check("R8 zero data", sd, 0); check("R8 oe kept", oe, 1);
    end
    en = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9 disable releases oe", oe, 0); check("R9 disable clears fs", fs, 0);
    check("R8 sticky", urun, 1);
    uclr = 1'b1; @(negedge clk); uclr = 1'b0;
    check("R8 cleared", urun, 0);

    // R8 DMA underrun, R3 request while empty
    do_reset();
    asg = 4'h1; den = 4'h1; last = 2'd0;
    @(negedge clk);
    check("R3 req while empty", dreq, 4'h1);
    en = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 dma underrun flag", urun, 1);
    @(posedge clk); @(negedge clk);
    check("R8 dma zero msb", sd, 0);
    en = 1'b0;
    @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule